// File: doc/BRIEF.md
# Interrupt Entry Bus Sequencer

This block drives the bus cycles a small processor core performs when it takes a maskable interrupt. While idle it watches an interrupt request together with an end-of-instruction strobe; the request is only taken at an instruction boundary, and the source number in force at that boundary selects the vector. Once the request is taken, the block captures the next-fetch address, the condition-code byte and the stack pointer, and runs a fixed eight-cycle sequence on a single-cycle address/read/write/data bus.

The sequence is: two instruction prefetches whose code is thrown away, the first of which gives the return address; one idle internal cycle; a push of the return address one word below the stack pointer; a push of the condition-code byte two words below it; a read of the vector table entry, whose data is the handler start address; another idle internal cycle; and finally the prefetch of the handler's first instruction, marked by a one-cycle done pulse. After that the block goes back to idle with the stack pointer output lowered by the frame size.

Top module: `irq_entry_sequencer`

## Requirements
- R1: After reset, and whenever no sequence is running, busy, done, busRd and busWr are 0 and busAddr is 0; spOut resets to 0. A sequence starts only on a clock edge where irqReq and instrEnd are both 1 while idle; a request withdrawn before instrEnd arrives, or an instrEnd without a request, starts nothing.
- R2: The first bus cycle after the accepting edge is a read at the captured pcIn (the return address).
- R3: The second cycle is a read at pcIn + 2.
- R4: The third cycle is an internal cycle: busRd and busWr both 0.
- R5: The fourth cycle is a write at SP − 2 (SP captured at acceptance) with busWdata equal to the return address.
- R6: The fifth cycle is a write at SP − 4 with busWdata equal to the condition-code byte in bits 7:0 and zeros above.
- R7: The sixth cycle is a read at VEC_BASE + src × VEC_SIZE, where src is srcNum sampled on the accepting edge (defaults: base 0x0040, entry size 2).
- R8: The seventh cycle is an internal cycle with no read or write.
- R9: The eighth cycle is a read at the busRdata value presented in the vector cycle, with done = 1 in that cycle only; the next cycle is idle.
- R10: From the vector cycle onward spOut equals the accepted SP − 4 (16-bit wrap), and it holds that value until the next sequence updates it.
- R11: busRd and busWr are never 1 in the same cycle.
- R12: Changes on irqReq, instrEnd, srcNum, pcIn, spIn and ccrIn while a sequence runs do not alter its addresses, data or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | 1 | Maskable interrupt request level |
| srcNum | input | SRC_W | Number of the requesting source |
| instrEnd | input | 1 | Current instruction completes this cycle |
| pcIn | input | W | Address of the next instruction prefetch |
| spIn | input | W | Current stack pointer |
| ccrIn | input | CCR_W | Current condition-code byte |
| busRdata | input | W | Read data from the bus |
| busAddr | output | W | Bus address |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| busWdata | output | W | Write data |
| spOut | output | W | Stack pointer after the frame push |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Handler first-instruction prefetch this cycle |

## Verification
The awkward case is a request that is raised, sits through several cycles without an instruction boundary, and then either vanishes just before the boundary or is taken with a source number that changed during the wait. The stimulus holds the request for a random number of cycles with instrEnd low, varies srcNum throughout, and then either lowers the request one cycle before the boundary or keeps it. While a sequence runs, every input including busRdata is scrambled outside the vector cycle, so any capture in the wrong cycle shows up in the pushed data or the handler address.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PF1, ST_PF2, ST_INT1, ST_WR1, ST_WR2, ST_VEC, ST_INT2, ST_PFH
  } seqState_e;

  typedef enum logic [2:0] {
    ASEL_NONE, ASEL_PC, ASEL_PC2, ASEL_SP2, ASEL_SP4, ASEL_VEC, ASEL_HND
  } addrSel_e;

  typedef struct packed {
    logic     load;
    addrSel_e addrSel;
    logic     rd;
    logic     wr;
    logic     capVec;
    logic     updSp;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        irqReq,
  input  logic        instrEnd,
  output ctrlStrobe_t strb,
  output logic        busy,
  output logic        done
);

  seqState_e state, stateNext;
  logic      accept;

  assign accept = (state == ST_IDLE) && irqReq && instrEnd;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept) stateNext = ST_PF1;
      ST_PF1:  stateNext = ST_PF2;
      ST_PF2:  stateNext = ST_INT1;
      ST_INT1: stateNext = ST_WR1;
      ST_WR1:  stateNext = ST_WR2;
      ST_WR2:  stateNext = ST_VEC;
      ST_VEC:  stateNext = ST_INT2;
      ST_INT2: stateNext = ST_PFH;
      ST_PFH:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb         = '0;
    strb.addrSel = ASEL_NONE;
    strb.load    = accept;
    unique case (state)
      ST_PF1: begin strb.addrSel = ASEL_PC;  strb.rd = 1'b1; end
      ST_PF2: begin strb.addrSel = ASEL_PC2; strb.rd = 1'b1; end
      ST_WR1: begin strb.addrSel = ASEL_SP2; strb.wr = 1'b1; end
      ST_WR2: begin strb.addrSel = ASEL_SP4; strb.wr = 1'b1; strb.updSp = 1'b1; end
      ST_VEC: begin strb.addrSel = ASEL_VEC; strb.rd = 1'b1; strb.capVec = 1'b1; end
      ST_PFH: begin strb.addrSel = ASEL_HND; strb.rd = 1'b1; end
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_PFH);

  // R1: no start without a request at an instruction boundary
  p_no_spurious_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(irqReq && instrEnd)) |=> !busy);

  // R9: done is a single cycle and is followed by idle
  p_done_then_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!busy && !done));

  // R11: read and write strobes never coincide
  p_rd_wr_exclusive_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rd && strb.wr));

  // R12: once started the sequence runs through regardless of inputs
  p_runs_through_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int W          = 16,
  parameter int SRC_W      = 4,
  parameter int CCR_W      = 8,
  parameter int VEC_BASE   = 'h0040,
  parameter int VEC_SIZE   = 2,
  parameter int WORD_BYTES = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [SRC_W-1:0] srcNum,
  input  logic [W-1:0]     pcIn,
  input  logic [W-1:0]     spIn,
  input  logic [CCR_W-1:0] ccrIn,
  input  logic [W-1:0]     busRdata,
  output logic [W-1:0]     busAddr,
  output logic             busRd,
  output logic             busWr,
  output logic [W-1:0]     busWdata,
  output logic [W-1:0]     spOut
);

  localparam logic [W-1:0] BASE_L  = W'(VEC_BASE);
  localparam logic [W-1:0] ENTRY_L = W'(VEC_SIZE);
  localparam logic [W-1:0] STEP_L  = W'(WORD_BYTES);
  localparam logic [W-1:0] FRAME_L = W'(2 * WORD_BYTES);

  logic [W-1:0]     pcReg, spReg, handlerReg, spOutReg;
  logic [CCR_W-1:0] ccrReg;
  logic [SRC_W-1:0] srcReg;
  logic [W-1:0]     vecAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg      <= '0;
      spReg      <= '0;
      ccrReg     <= '0;
      srcReg     <= '0;
      handlerReg <= '0;
      spOutReg   <= '0;
    end else begin
      if (strb.load) begin
        pcReg  <= pcIn;
        spReg  <= spIn;
        ccrReg <= ccrIn;
        srcReg <= srcNum;
      end
      if (strb.capVec) handlerReg <= busRdata;
      if (strb.updSp)  spOutReg   <= spReg - FRAME_L;
    end
  end

  assign vecAddr = BASE_L + W'(srcReg) * ENTRY_L;

  always_comb begin
    unique case (strb.addrSel)
      ASEL_PC:  busAddr = pcReg;
      ASEL_PC2: busAddr = pcReg + STEP_L;
      ASEL_SP2: busAddr = spReg - STEP_L;
      ASEL_SP4: busAddr = spReg - FRAME_L;
      ASEL_VEC: busAddr = vecAddr;
      ASEL_HND: busAddr = handlerReg;
      default:  busAddr = '0;
    endcase
  end

  always_comb begin
    unique case (strb.addrSel)
      ASEL_SP2: busWdata = pcReg;
      ASEL_SP4: busWdata = W'(ccrReg);
      default:  busWdata = '0;
    endcase
  end

  assign busRd = strb.rd;
  assign busWr = strb.wr;
  assign spOut = spOutReg;

  // R5: the first push carries the address of the first discarded prefetch
  p_push_return_pc_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addrSel == ASEL_SP2) |-> (busWdata == $past(busAddr, 3)));

  // R6: the second push lands one word below the first
  p_push_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addrSel == ASEL_SP4) |-> ($past(busWr) && busAddr == $past(busAddr) - STEP_L));

  // R9: the handler prefetch uses the data read in the vector cycle
  p_handler_from_vector_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addrSel == ASEL_HND) |-> (busAddr == $past(busRdata, 2)));

  // R10: stack pointer output is lowered by the frame when the handler is fetched
  p_sp_frame_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addrSel == ASEL_HND) |-> (spOut == $past(busAddr, 3)));

endmodule

// File: rtl/irq_entry_sequencer.sv
module irq_entry_sequencer
  import irq_entry_pkg::*;
#(
  parameter int W          = 16,
  parameter int SRC_W      = 4,
  parameter int CCR_W      = 8,
  parameter int VEC_BASE   = 'h0040,
  parameter int VEC_SIZE   = 2,
  parameter int WORD_BYTES = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             irqReq,
  input  logic [SRC_W-1:0] srcNum,
  input  logic             instrEnd,
  input  logic [W-1:0]     pcIn,
  input  logic [W-1:0]     spIn,
  input  logic [CCR_W-1:0] ccrIn,
  input  logic [W-1:0]     busRdata,
  output logic [W-1:0]     busAddr,
  output logic             busRd,
  output logic             busWr,
  output logic [W-1:0]     busWdata,
  output logic [W-1:0]     spOut,
  output logic             busy,
  output logic             done
);

  ctrlStrobe_t strb;

  irq_entry_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .irqReq   (irqReq),
    .instrEnd (instrEnd),
    .strb     (strb),
    .busy     (busy),
    .done     (done)
  );

  irq_entry_dp #(
    .W(W), .SRC_W(SRC_W), .CCR_W(CCR_W),
    .VEC_BASE(VEC_BASE), .VEC_SIZE(VEC_SIZE), .WORD_BYTES(WORD_BYTES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .srcNum   (srcNum),
    .pcIn     (pcIn),
    .spIn     (spIn),
    .ccrIn    (ccrIn),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .busRd    (busRd),
    .busWr    (busWr),
    .busWdata (busWdata),
    .spOut    (spOut)
  );

endmodule

// File: tb/sim_irq_entry_sequencer.sv
`timescale 1ns/1ps
module sim_irq_entry_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irqReq = 1'b0;
  logic [3:0]  srcNum = '0;
  logic        instrEnd = 1'b0;
  logic [15:0] pcIn = '0, spIn = '0, busRdata = '0;
  logic [7:0]  ccrIn = '0;
  logic [15:0] busAddr, busWdata, spOut;
  logic        busRd, busWr, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_entry_sequencer u0 (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .srcNum(srcNum), .instrEnd(instrEnd),
    .pcIn(pcIn), .spIn(spIn), .ccrIn(ccrIn), .busRdata(busRdata),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .spOut(spOut), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] vecOf(input logic [3:0] s);
    return 16'h0040 + 16'(s) * 16'd2;
  endfunction

  // bus signature {rd, wr, done, busy}
  task automatic chkBus(input string req, input logic [15:0] a, input bit rd, input bit wr, input bit dn);
    chk(busAddr == a, req, busAddr, a);
    chk({busRd, busWr, done, busy} == {rd, wr, dn, 1'b1}, req, {busRd, busWr, done, busy}, {rd, wr, dn, 1'b1});
    chk(!(busRd && busWr), "R11", {busRd, busWr}, 0);
  endtask

  task automatic chkIdle(input string req);
    chk({busy, done, busRd, busWr} == 4'b0 && busAddr == 16'h0, req, {busy, done, busRd, busWr, busAddr}, 0);
  endtask

  task automatic scramble();
    irqReq   = 1'($urandom);
    instrEnd = 1'($urandom);
    srcNum   = 4'($urandom);
    pcIn     = 16'($urandom);
    spIn     = 16'($urandom);
    ccrIn    = 8'($urandom);
  endtask

  // Raise a request, wait, accept, then check all eight cycles.
  task automatic runSeq(input logic [15:0] pc, input logic [15:0] sp, input logic [7:0] ccr,
                        input logic [3:0] src, input logic [15:0] hnd, input int waitCyc,
                        input bit noise);
    logic [15:0] oldSp;
    oldSp = spOut;
    irqReq = 1'b1;
    instrEnd = 1'b0;
    for (int i = 0; i < waitCyc; i++) begin
      srcNum = 4'($urandom);
      @(posedge clk); @(negedge clk);
      chkIdle("R1");
      chk(spOut == oldSp, "R10", spOut, oldSp);
    end
    srcNum = src; pcIn = pc; spIn = sp; ccrIn = ccr; instrEnd = 1'b1;
    @(posedge clk); @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      busRdata = (k == 5) ? hnd : 16'($urandom);
      if (noise) scramble(); else begin irqReq = 1'b0; instrEnd = 1'b0; end
      case (k)
        0: chkBus("R2", pc, 1, 0, 0);
        1: chkBus("R3", pc + 16'd2, 1, 0, 0);
        2: chkBus("R4", 16'h0, 0, 0, 0);
        3: begin chkBus("R5", sp - 16'd2, 0, 1, 0); chk(busWdata == pc, "R5", busWdata, pc); end
        4: begin chkBus("R6", sp - 16'd4, 0, 1, 0); chk(busWdata == {8'h00, ccr}, "R6", busWdata, {8'h00, ccr}); end
        5: begin chkBus("R7", vecOf(src), 1, 0, 0); chk(spOut == sp - 16'd4, "R10", spOut, sp - 16'd4); end
        6: chkBus("R8", 16'h0, 0, 0, 0);
        7: begin chkBus("R9", hnd, 1, 0, 1); chk(spOut == sp - 16'd4, "R10", spOut, sp - 16'd4); end
        default: ;
      endcase
      @(posedge clk); @(negedge clk);
    end
    irqReq = 1'b0; instrEnd = 1'b0;
    chkIdle("R9");
    chk(spOut == sp - 16'd4, "R10", spOut, sp - 16'd4);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    chkIdle("R1");
    chk(spOut == 16'h0, "R1", spOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1");

    // R1: instrEnd alone does nothing
    instrEnd = 1'b1;
    repeat (3) begin @(posedge clk); @(negedge clk); chkIdle("R1"); end
    instrEnd = 1'b0;

    // R1: request withdrawn one cycle before the boundary
    irqReq = 1'b1;
    repeat (4) begin @(posedge clk); @(negedge clk); chkIdle("R1"); end
    irqReq = 1'b0; instrEnd = 1'b1;
    repeat (3) begin @(posedge clk); @(negedge clk); chkIdle("R1"); chk(spOut == 16'h0, "R10", spOut, 0); end
    instrEnd = 1'b0;

    // Directed: immediate acceptance, typical frame
    runSeq(16'h1234, 16'h8000, 8'hA5, 4'd3, 16'h2000, 0, 1'b0);
    // R7/R10 corners: largest source, stack wrap below zero
    runSeq(16'hFFFE, 16'h0002, 8'hFF, 4'd15, 16'hBEEF, 2, 1'b0);
    // R12: inputs scrambled during the sequence
    runSeq(16'h0400, 16'hFF00, 8'h3C, 4'd0, 16'h0100, 1, 1'b1);
    // Back-to-back: accept on the first idle cycle after done
    runSeq(16'h5000, 16'h7FF0, 8'h01, 4'd7, 16'h6000, 0, 1'b0);

    for (int n = 0; n < 40; n++) begin
      if ($urandom % 4 == 0) begin
        irqReq = 1'b1; instrEnd = 1'b0;
        repeat (1 + $urandom % 4) begin @(posedge clk); @(negedge clk); chkIdle("R1"); end
        irqReq = 1'b0; instrEnd = 1'b1;
        @(posedge clk); @(negedge clk); chkIdle("R1");
        instrEnd = 1'b0;
      end
      runSeq(16'($urandom) & 16'hFFFE, 16'($urandom) & 16'hFFFE, 8'($urandom), 4'($urandom),
             16'($urandom), int'($urandom % 6), 1'($urandom));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule